// File: doc/BRIEF.md
# Memory Read/Write Turnaround Scheduler

This block decides, cycle by cycle, whether a memory controller issues a read burst or a write burst. It also steers the shared data bus between the read and write directions. It watches the occupancy of the read and write queues and a drain request. It grants a read or a write to the command back end, which answers with a burst acknowledge when the burst goes out.

A four-state direction machine controls the switching. Reads are preferred. Writes are drained when their queue passes a high watermark, or when the reads run dry and the writes pass a low watermark. A minimum-writes hysteresis keeps the bus from flipping back after only a few writes. The block keeps a bus-busy-until cycle value that includes the turnaround bubbles, and the bubbles are not the same in both directions. A read-to-write turn adds only the read-to-write gap. A write-to-read turn adds the write-to-read gap plus the CAS latency. From bus-busy-until the block derives the earliest cycle at which the next request is considered: bus-busy-until minus the worst-case bank preparation (precharge + activate + CAS). This lets bank preparation overlap the bus turnaround.

All timings, watermarks and the minimum-writes value are static inputs given in clock cycles, and the write high watermark must not be below the low watermark.

Top module: `rw_turnaround_sched`

## Requirements
- R1: While rst_ni is low, state_o is 0 (READ), rd_grant_o, wr_grant_o and drain_done_o are 0, and busy_until_o is 0. The state encoding is READ=0, READ_TO_WRITE=1, WRITE=2, WRITE_TO_READ=3.
- R2: An internal cycle counter is 0 at the first clock edge after reset and advances by one per cycle. At that first edge busy_until_o becomes the counter value plus t_rp_i + t_rcd_i + t_cl_i, and no grant is given in that first cycle.
- R3: In READ with a read count of zero, the block steps to READ_TO_WRITE when the write count is non-zero and either exceeds wr_low_i or drain_i is high. busy_until_o grows by t_rtw_i on that step.
- R4: In READ, a read burst that is acknowledged while the write count exceeds wr_high_i also steps the block to READ_TO_WRITE, and adds t_rtw_i on top of the burst's own update.
- R5: In WRITE, an acknowledged write burst steps the block to WRITE_TO_READ when the writes left after it (write count minus one) is zero, or when writes-left plus min_wr_i is below wr_low_i with drain_i low, or when reads are waiting and the writes issued in this write period, including this one, reach min_wr_i. A WRITE step with an empty write queue also goes to WRITE_TO_READ.
- R6: Every step into WRITE_TO_READ adds t_wtr_i + t_cl_i to busy_until_o.
- R7: next_req_o equals busy_until_o minus (t_rp_i + t_rcd_i + t_cl_i), but never less than the current cycle. Grants and state steps happen only in cycles where next_req_o equals the current cycle.
- R8: On its next step, READ_TO_WRITE passes to WRITE and WRITE_TO_READ passes to READ, and the count of bursts for the period is cleared.
- R9: Every acknowledged burst sets busy_until_o to the larger of the current cycle and the old busy_until_o, plus t_burst_i. Bursts are therefore at least t_burst_i apart on the bus.
- R10: In READ with no reads, and with write count at or below wr_low_i and drain_i low, the block gives no grant and stays in READ.
- R11: drain_done_o is high in READ after the first cycle whenever drain_i is high and both queue counts are zero.
- R12: A grant is a level that stays high until burst_ack_i is seen. A burst is counted only in a cycle with both grant and acknowledge, and rd_grant_o and wr_grant_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_count_i | input | QW | Read queue occupancy |
| wr_count_i | input | QW | Write queue occupancy |
| drain_i | input | 1 | Drain request, flush writes |
| burst_ack_i | input | 1 | Back end accepted the granted burst |
| t_rtw_i | input | TW | Read-to-write gap, cycles |
| t_wtr_i | input | TW | Write-to-read gap, cycles |
| t_cl_i | input | TW | CAS latency, cycles |
| t_rp_i | input | TW | Precharge time, cycles |
| t_rcd_i | input | TW | Activate-to-column time, cycles |
| t_burst_i | input | TW | Burst length on the bus, cycles |
| wr_low_i | input | QW | Write low watermark |
| wr_high_i | input | QW | Write high watermark |
| min_wr_i | input | QW | Minimum writes per write period |
| rd_grant_o | output | 1 | Issue a read burst |
| wr_grant_o | output | 1 | Issue a write burst |
| state_o | output | 2 | Direction state |
| bus_write_o | output | 1 | Bus is in write direction |
| busy_until_o | output | CW | Cycle at which the data bus becomes free |
| next_req_o | output | CW | Earliest cycle to consider the next request |
| drain_done_o | output | 1 | Drain complete |

## Verification
The bench uses the default widths (6-bit queue counts, 32-bit cycle values, 6-bit timings). It sets t_rtw_i=2, t_wtr_i=4, t_cl_i=3, t_rp_i=3, t_rcd_i=3, t_burst_i=4, a low watermark of 4, a high watermark of 8 and a minimum of 2 writes. With these settings, nine writes against five reads cross the high watermark after one read. The hysteresis then ends the write period after exactly two writes, the empty-read path crosses the low watermark with seven writes, and the low-watermark exit leaves a single write parked in the idle case until drain pushes it out. The small preparation time of 9 cycles against a 4-cycle burst lets reads run ahead of the bus. A 6-cycle acknowledge stall then shows the grant being held.

// File: rtl/rw_sched_pkg.sv
`timescale 1ns/1ps
package rw_sched_pkg;
  typedef enum logic [1:0] {
    ST_READ  = 2'd0,
    ST_RD2WR = 2'd1,
    ST_WRITE = 2'd2,
    ST_WR2RD = 2'd3
  } bus_state_e;
endpackage

// File: rtl/rw_sched_timer.sv
`timescale 1ns/1ps
module rw_sched_timer #(
  parameter int CW = 32,
  parameter int TW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] t_rp_i,
  input  logic [TW-1:0] t_rcd_i,
  input  logic [TW-1:0] t_cl_i,
  input  logic [TW-1:0] t_burst_i,
  input  logic          burst_i,
  input  logic [TW:0]   bubble_i,
  output logic          started_o,
  output logic          due_o,
  output logic [CW-1:0] busy_until_o,
  output logic [CW-1:0] next_req_o
);
  logic [CW-1:0] now_q, bbu_q, bbu_d;
  logic [CW-1:0] prep, raw_next, bus_free;
  logic          started_q;

  assign prep     = CW'(t_rp_i) + CW'(t_rcd_i) + CW'(t_cl_i);
  assign raw_next = bbu_q - prep;
  assign due_o    = started_q && (now_q >= raw_next);
  assign bus_free = (now_q > bbu_q) ? now_q : bbu_q;

  always_comb begin
    bbu_d = bbu_q;
    if (burst_i) bbu_d = bus_free + CW'(t_burst_i);
    bbu_d = bbu_d + CW'(bubble_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      now_q     <= '0;
      bbu_q     <= '0;
      started_q <= 1'b0;
    end else begin
      now_q <= now_q + CW'(1);
      if (!started_q) begin
        // push busy-until ahead so the preparation subtraction stays positive
        bbu_q     <= now_q + prep;
        started_q <= 1'b1;
      end else begin
        bbu_q <= bbu_d;
      end
    end
  end

  assign started_o    = started_q;
  assign busy_until_o = bbu_q;
  assign next_req_o   = due_o ? now_q : raw_next;

  p_busy_monotone_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    started_q |=> (bbu_q >= $past(bbu_q)));
  p_burst_spacing_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && burst_i) |=> (bbu_q >= $past(bbu_q) + CW'($past(t_burst_i))));
endmodule

// File: rtl/rw_sched_switch_cond.sv
`timescale 1ns/1ps
module rw_sched_switch_cond #(
  parameter int QW   = 6,
  parameter int CNTW = 8
) (
  input  logic [QW-1:0]   rd_count_i,
  input  logic [QW-1:0]   wr_count_i,
  input  logic            drain_i,
  input  logic [QW-1:0]   wr_low_i,
  input  logic [QW-1:0]   wr_high_i,
  input  logic [QW-1:0]   min_wr_i,
  input  logic [CNTW-1:0] wr_done_i,
  output logic            rd_idle_sw_o,
  output logic            rd_high_sw_o,
  output logic            wr_exit_o
);
  localparam int XW = ((CNTW > QW) ? CNTW : QW) + 1;

  logic [QW-1:0] wr_left;
  logic [QW:0]   left_plus_min;
  logic          left_empty, below_low, enough_writes;

  assign rd_idle_sw_o = (wr_count_i != '0) && ((wr_count_i > wr_low_i) || drain_i);
  assign rd_high_sw_o = wr_count_i > wr_high_i;

  assign wr_left       = wr_count_i - QW'(1);
  assign left_plus_min = {1'b0, wr_left} + {1'b0, min_wr_i};
  assign left_empty    = wr_left == '0;
  assign below_low     = (left_plus_min < {1'b0, wr_low_i}) && !drain_i;
  assign enough_writes = (rd_count_i != '0) && (XW'(wr_done_i) >= XW'(min_wr_i));
  assign wr_exit_o     = left_empty || below_low || enough_writes;
endmodule

// File: rtl/rw_sched_fsm.sv
`timescale 1ns/1ps
module rw_sched_fsm
  import rw_sched_pkg::*;
#(
  parameter int QW   = 6,
  parameter int TW   = 6,
  parameter int CNTW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            started_i,
  input  logic            due_i,
  input  logic [QW-1:0]   rd_count_i,
  input  logic [QW-1:0]   wr_count_i,
  input  logic            drain_i,
  input  logic            burst_ack_i,
  input  logic            rd_idle_sw_i,
  input  logic            rd_high_sw_i,
  input  logic            wr_exit_i,
  input  logic [TW-1:0]   t_rtw_i,
  input  logic [TW-1:0]   t_wtr_i,
  input  logic [TW-1:0]   t_cl_i,
  output bus_state_e      state_o,
  output logic [CNTW-1:0] cnt_inc_o,
  output logic            rd_grant_o,
  output logic            wr_grant_o,
  output logic            burst_o,
  output logic [TW:0]     bubble_o,
  output logic            drain_done_o
);
  bus_state_e    state_q, state_d;
  logic [CNTW-1:0] cnt_q, cnt_d;
  logic          act;
  logic [TW:0]   rtw_gap, wtr_gap;

  assign act       = started_i && due_i;
  assign cnt_inc_o = (cnt_q == '1) ? cnt_q : cnt_q + CNTW'(1);
  assign rtw_gap   = {1'b0, t_rtw_i};
  assign wtr_gap   = {1'b0, t_wtr_i} + {1'b0, t_cl_i};

  always_comb begin
    state_d      = state_q;
    cnt_d        = cnt_q;
    rd_grant_o   = 1'b0;
    wr_grant_o   = 1'b0;
    burst_o      = 1'b0;
    bubble_o     = '0;
    drain_done_o = 1'b0;
    unique case (state_q)
      ST_READ: begin
        if (rd_count_i != '0) begin
          rd_grant_o = act;
          if (act && burst_ack_i) begin
            burst_o = 1'b1;
            cnt_d   = cnt_inc_o;
            if (rd_high_sw_i) begin
              state_d  = ST_RD2WR;
              bubble_o = rtw_gap;
            end
          end
        end else if (rd_idle_sw_i) begin
          if (act) begin
            state_d  = ST_RD2WR;
            bubble_o = rtw_gap;
          end
        end else begin
          drain_done_o = started_i && drain_i && (wr_count_i == '0);
        end
      end
      ST_RD2WR: begin
        if (act) begin
          state_d = ST_WRITE;
          cnt_d   = '0;
        end
      end
      ST_WRITE: begin
        if (wr_count_i != '0) begin
          wr_grant_o = act;
          if (act && burst_ack_i) begin
            burst_o = 1'b1;
            cnt_d   = cnt_inc_o;
            if (wr_exit_i) begin
              state_d  = ST_WR2RD;
              bubble_o = wtr_gap;
            end
          end
        end else if (act) begin
          state_d  = ST_WR2RD;
          bubble_o = wtr_gap;
        end
      end
      ST_WR2RD: begin
        if (act) begin
          state_d = ST_READ;
          cnt_d   = '0;
        end
      end
      default: state_d = ST_READ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_READ;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;

  p_one_grant_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_grant_o && wr_grant_o));
  p_rd2wr_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD2WR) |=> (state_q inside {ST_RD2WR, ST_WRITE}));
  p_wr2rd_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WR2RD) |=> (state_q inside {ST_WR2RD, ST_READ}));
  p_drain_done_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_done_o |-> (state_q == ST_READ && rd_count_i == '0 && wr_count_i == '0));
endmodule

// File: rtl/rw_turnaround_sched.sv
`timescale 1ns/1ps
module rw_turnaround_sched
  import rw_sched_pkg::*;
#(
  parameter int QW   = 6,
  parameter int CW   = 32,
  parameter int TW   = 6,
  parameter int CNTW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [QW-1:0] rd_count_i,
  input  logic [QW-1:0] wr_count_i,
  input  logic          drain_i,
  input  logic          burst_ack_i,
  input  logic [TW-1:0] t_rtw_i,
  input  logic [TW-1:0] t_wtr_i,
  input  logic [TW-1:0] t_cl_i,
  input  logic [TW-1:0] t_rp_i,
  input  logic [TW-1:0] t_rcd_i,
  input  logic [TW-1:0] t_burst_i,
  input  logic [QW-1:0] wr_low_i,
  input  logic [QW-1:0] wr_high_i,
  input  logic [QW-1:0] min_wr_i,
  output logic          rd_grant_o,
  output logic          wr_grant_o,
  output logic [1:0]    state_o,
  output logic          bus_write_o,
  output logic [CW-1:0] busy_until_o,
  output logic [CW-1:0] next_req_o,
  output logic          drain_done_o
);
  bus_state_e      state;
  logic            started, due, burst;
  logic [TW:0]     bubble;
  logic [CNTW-1:0] cnt_inc;
  logic            rd_idle_sw, rd_high_sw, wr_exit;

  rw_sched_timer #(.CW(CW), .TW(TW)) u_timer (
    .clk_i, .rst_ni,
    .t_rp_i, .t_rcd_i, .t_cl_i, .t_burst_i,
    .burst_i(burst), .bubble_i(bubble),
    .started_o(started), .due_o(due),
    .busy_until_o, .next_req_o
  );

  rw_sched_switch_cond #(.QW(QW), .CNTW(CNTW)) u_cond (
    .rd_count_i, .wr_count_i, .drain_i,
    .wr_low_i, .wr_high_i, .min_wr_i,
    .wr_done_i(cnt_inc),
    .rd_idle_sw_o(rd_idle_sw), .rd_high_sw_o(rd_high_sw), .wr_exit_o(wr_exit)
  );

  rw_sched_fsm #(.QW(QW), .TW(TW), .CNTW(CNTW)) u_fsm (
    .clk_i, .rst_ni,
    .started_i(started), .due_i(due),
    .rd_count_i, .wr_count_i, .drain_i, .burst_ack_i,
    .rd_idle_sw_i(rd_idle_sw), .rd_high_sw_i(rd_high_sw), .wr_exit_i(wr_exit),
    .t_rtw_i, .t_wtr_i, .t_cl_i,
    .state_o(state), .cnt_inc_o(cnt_inc),
    .rd_grant_o, .wr_grant_o,
    .burst_o(burst), .bubble_o(bubble),
    .drain_done_o
  );

  assign state_o     = state;
  assign bus_write_o = state == ST_WRITE;

  p_rtw_bubble_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_RD2WR && $past(state) == ST_READ) |->
      (busy_until_o >= $past(busy_until_o) + CW'($past(t_rtw_i))));
  p_wtr_bubble_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state == ST_WR2RD && $past(state) == ST_WRITE) |->
      (busy_until_o >= $past(busy_until_o) + CW'($past(t_wtr_i)) + CW'($past(t_cl_i))));
  p_grant_in_dir_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_grant_o |-> state == ST_READ) and (wr_grant_o |-> state == ST_WRITE));
endmodule

// File: tb/rw_turnaround_sched_tb.sv
`timescale 1ns/1ps
module rw_turnaround_sched_tb;
  localparam int QW = 6, CW = 32, TW = 6;
  localparam int TRTW = 2, TWTR = 4, TCL = 3, TRP = 3, TRCD = 3, TB = 4;
  localparam int LOW = 4, HIGH = 8, MINW = 2;
  localparam int PREP = TRP + TRCD + TCL;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [QW-1:0] rd_count = '0, wr_count = '0;
  logic drain = 1'b0, ack = 1'b1;
  logic rd_grant, wr_grant, bus_write, drain_done;
  logic [1:0] state;
  logic [CW-1:0] busy_until, next_req;

  always #5 clk = ~clk;

  rw_turnaround_sched #(.QW(QW), .CW(CW), .TW(TW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .rd_count_i(rd_count), .wr_count_i(wr_count),
    .drain_i(drain), .burst_ack_i(ack),
    .t_rtw_i(TW'(TRTW)), .t_wtr_i(TW'(TWTR)), .t_cl_i(TW'(TCL)),
    .t_rp_i(TW'(TRP)), .t_rcd_i(TW'(TRCD)), .t_burst_i(TW'(TB)),
    .wr_low_i(QW'(LOW)), .wr_high_i(QW'(HIGH)), .min_wr_i(QW'(MINW)),
    .rd_grant_o(rd_grant), .wr_grant_o(wr_grant), .state_o(state),
    .bus_write_o(bus_write), .busy_until_o(busy_until),
    .next_req_o(next_req), .drain_done_o(drain_done)
  );

  int n_checks = 0, n_err = 0;
  int rd_q = 0, wr_q = 0;
  bit seen_grant;
  // reference state
  int m_state = 0, m_cnt = 0;
  longint m_now = 0, m_bbu = 0;
  bit m_started = 0;
  string m_tag = "R1";
  logic [1:0] exp_q[$];

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic cycle_step();
    bit due, act, g_rd, g_wr, dd, fire;
    int ns, nc;
    longint nb, free;
    string tag;
    rd_count = QW'(rd_q);
    wr_count = QW'(wr_q);
    #1;
    // driver side: expected outputs from requirement rules
    due  = m_started && (m_now >= m_bbu - PREP);
    act  = due;
    g_rd = (m_state == 0) && (rd_q != 0) && act;
    g_wr = (m_state == 2) && (wr_q != 0) && act;
    dd   = m_started && (m_state == 0) && drain && rd_q == 0 && wr_q == 0;
    exp_q.push_back({g_wr, g_rd});
    // monitor side
    chk("R12", "grant", {wr_grant, rd_grant}, exp_q.pop_front());
    chk(m_tag, "state", state, m_state);
    chk("R11", "drain_done", drain_done, dd);
    chk("R12", "bus_write", bus_write, m_state == 2);
    if (m_started) begin
      chk(m_tag, "busy_until", busy_until, m_bbu);
      chk("R7", "next_req", next_req, due ? m_now : m_bbu - PREP);
    end
    if (rd_grant || wr_grant) seen_grant = 1;
    // advance reference
    ns = m_state; nc = m_cnt; nb = m_bbu; tag = "R7";
    free = (m_now > m_bbu) ? m_now : m_bbu;
    fire = ack;
    if (!m_started) begin
      nb = m_now + PREP; m_started = 1; tag = "R2";
    end else begin
      case (m_state)
        0: if (rd_q != 0) begin
             if (g_rd && fire) begin
               nb = free + TB; nc = m_cnt + 1; tag = "R9";
               if (wr_q > HIGH) begin ns = 1; nb += TRTW; tag = "R4"; end
               rd_q--;
             end
           end else if (wr_q != 0 && (wr_q > LOW || drain)) begin
             if (act) begin ns = 1; nb += TRTW; tag = "R3"; end
           end else tag = "R10";
        1: if (act) begin ns = 2; nc = 0; tag = "R8"; end
        2: if (wr_q != 0) begin
             if (g_wr && fire) begin
               nb = free + TB; nc = m_cnt + 1; tag = "R9";
               if ((wr_q - 1 == 0) || ((wr_q - 1 + MINW) < LOW && !drain) ||
                   (rd_q != 0 && m_cnt + 1 >= MINW)) begin
                 ns = 3; nb += TWTR + TCL; tag = "R5/R6";
               end
               wr_q--;
             end
           end else if (act) begin ns = 3; nb += TWTR + TCL; tag = "R6"; end
        default: if (act) begin ns = 0; nc = 0; tag = "R8"; end
      endcase
    end
    m_state = ns; m_cnt = nc; m_bbu = nb; m_tag = tag;
    m_now++;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cycle_step();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "state", state, 0);
    chk("R1", "grants", {wr_grant, rd_grant}, 0);
    chk("R1", "drain_done", drain_done, 0);
    chk("R1", "busy_until", busy_until, 0);
    rst_n = 1'b1;
    run(1);
    chk("R2", "startup busy_until", busy_until, PREP);
    // R10 idle: nothing queued, then writes at the low watermark
    seen_grant = 0;
    run(10);
    wr_q = 3;
    run(20);
    chk("R10", "idle state", state, 0);
    chk("R10", "idle grants seen", seen_grant, 0);
    // R4 high watermark, R5 hysteresis, R3 low-watermark switch, R5 below-low exit
    rd_q = 5; wr_q = 9;
    run(300);
    chk("R5", "writes left parked", wr_q, 1);
    chk("R3", "reads served", rd_q, 0);
    chk("R10", "parked write idle state", state, 0);
    // R3 drain path, R11 drain done
    drain = 1'b1;
    run(100);
    chk("R11", "writes drained", wr_q, 0);
    chk("R11", "drain_done level", drain_done, 1);
    drain = 1'b0;
    // R12 acknowledge stall
    rd_q = 2; ack = 1'b0;
    run(6);
    chk("R12", "grant held", rd_grant, 1);
    chk("R12", "no burst without ack", rd_q, 2);
    ack = 1'b1;
    run(50);
    chk("R12", "reads after ack", rd_q, 0);
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule